// File: doc/BRIEF.md
# Interval Timer with Buffered Compare

This block is a 16-bit up-counting interval timer. Its count strobe comes from one of two sources. The first is one of eight power-of-two taps of the system clock. The second is the rising edges of an external event line, which is first brought into the clock domain by a synchronizer.

While the run input is low, the counter rests at all ones and the timer output is low. When the run input goes high, the first count strobe does three things: it moves the counter to zero, copies the compare input into a shadow buffer, and toggles the timer output. From then on, each strobe adds one to the count. On the strobe that finds the count equal to the shadow buffer, the counter returns to zero, the timer output toggles and a one-cycle interrupt pulse is raised. The same strobe refreshes the buffer from the compare input.

Software may therefore rewrite the compare value at any time. The new value governs only the period that starts at the next load point. The interval between matches is (compare value + 1) count strobes.

Top module: `intv_timer`

## Requirements
- R1: After reset, and on the clock edge after any edge at which `run_en` is sampled low, `count` is FFFFH, `tmr_out` is 0 and `match_irq` is 0.
- R2: With `run_en` high, the first count strobe sets `count` to 0000H and toggles `tmr_out` from 0 to 1.
- R3: With the timer running, each later count strobe that is not a match adds one to `count`. Between strobes, `count` and `tmr_out` hold.
- R4: A count strobe that finds `count` equal to the shadow buffer sets `count` to 0000H, toggles `tmr_out` and raises `match_irq`.
- R5: Consecutive matches are (buffer value + 1) count strobes apart.
- R6: `cmp_val` is copied into the shadow buffer only at the start strobe (R2) and at each match strobe (R4). A change at any other time first takes effect in the period that begins at the next such strobe.
- R7: In internal mode (`evt_mode` = 0), `clk_sel` = k gives one count strobe every 2^k clock cycles. The first strobe falls on the 2^k-th clock edge at which `run_en` is sampled high, counting from the first such edge.
- R8: In external mode (`evt_mode` = 1), each rising edge of `evt_in` gives exactly one count strobe. That strobe acts on the third clock edge that samples `evt_in` high. A level held high gives no further strobes, and the internal taps have no effect.
- R9: Dropping `run_en` and raising it again restarts the timer as in R2, with the buffer loaded again from `cmp_val`.
- R10: `match_irq` is high for one clock cycle per match and low in the cycle after a match, unless that cycle is itself a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | 1 = count, 0 = stop and rest at FFFFH |
| clk_sel | input | 3 | Internal tap select: strobe every 2^clk_sel cycles |
| evt_mode | input | 1 | 1 = count `evt_in` rising edges, 0 = internal taps |
| evt_in | input | 1 | Asynchronous external event line |
| cmp_val | input | 16 | Compare value, loaded into the shadow buffer at load points |
| tmr_out | output | 1 | Timer output, toggles at start and at each match |
| match_irq | output | 1 | One-cycle compare-match interrupt pulse |
| count | output | 16 | Current counter value |

## Verification
Every result is registered, so a strobe is visible on the ports one cycle after the edge that carries it. With tap k, the first strobe appears 2^k cycles after the edge that samples `run_en` high. An external pulse shows up 3 cycles after the edge that first samples `evt_in` high, and a stop shows up one cycle after the edge that samples `run_en` low.

The driver computes each absolute due cycle from these latencies and queues the expected count, output and interrupt for that cycle. The monitor samples on the falling edge and compares only entries due in the current cycle. An entry that is overdue is reported as a mismatch. Hold cycles are queued just before a strobe is due, so early counting is caught as well.

// File: rtl/intv_pkg.sv
package intv_pkg;

  // Counter phase: waiting for the start strobe, or counting.
  typedef enum logic [0:0] {
    PH_WAIT = 1'b0,
    PH_RUN  = 1'b1
  } phase_t;

endpackage

// File: rtl/intv_evsync.sv
// Brings the external event line into the clock domain and flags its rising edges.
module intv_evsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_in,
  output logic edge_o
);

  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q, prev_d;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_chain
      if (i == 0) begin : g_first
        assign sync_d[i] = evt_in;
      end else begin : g_next
        assign sync_d[i] = sync_q[i-1];
      end
    end
  endgenerate

  assign prev_d = sync_q[STAGES-1];
  assign edge_o = sync_q[STAGES-1] & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  // R8: a held level never yields two strobes in a row
  p_edge_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |=> !edge_o);

endmodule

// File: rtl/intv_strobe.sv
// Count strobe source: one of 2**SEL_W prescaler taps, or the synchronized event edge.
module intv_strobe #(
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic [SEL_W-1:0] sel,
  input  logic             ext_mode,
  input  logic             ext_edge,
  output logic             tick_o
);

  localparam int unsigned NTAP  = 1 << SEL_W;
  localparam int unsigned DIV_W = NTAP - 1;

  logic [DIV_W-1:0] div_q, div_d;
  logic [NTAP-1:0]  tap;

  // Tap k fires when the low k divider bits are all ones.
  generate
    for (genvar k = 0; k < NTAP; k++) begin : g_tap
      if (k == 0) begin : g_full
        assign tap[k] = 1'b1;
      end else begin : g_div
        assign tap[k] = &div_q[k-1:0];
      end
    end
  endgenerate

  always_comb begin
    if (run_en) div_d = div_q + DIV_W'(1);
    else        div_d = '0;
  end

  assign tick_o = run_en & (ext_mode ? ext_edge : tap[sel]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  // R7: with a divided tap held steady, strobes never come back to back
  p_tap_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && !ext_mode && sel != '0) ##1 ($stable(sel) && !ext_mode && run_en)
      |-> !tick_o);

endmodule

// File: rtl/intv_core.sv
// Counter, shadow compare buffer, timer output and match pulse.
module intv_core
  import intv_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             tick,
  input  logic [CNT_W-1:0] cmp_val,
  output logic [CNT_W-1:0] cnt_o,
  output logic             out_o,
  output logic             irq_o
);

  phase_t           ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] buf_q, buf_d;
  logic             out_q, out_d;
  logic             irq_q, irq_d;
  logic             hit;

  assign hit = (cnt_q == buf_q);

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    buf_d = buf_q;
    out_d = out_q;
    irq_d = 1'b0;
    if (!run_en) begin
      ph_d  = PH_WAIT;
      cnt_d = '1;
      out_d = 1'b0;
    end else if (tick) begin
      if (ph_q == PH_WAIT) begin
        ph_d  = PH_RUN;
        cnt_d = '0;
        buf_d = cmp_val;
        out_d = ~out_q;
      end else if (hit) begin
        cnt_d = '0;
        buf_d = cmp_val;
        out_d = ~out_q;
        irq_d = 1'b1;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_WAIT;
      cnt_q <= '1;
      buf_q <= '0;
      out_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      buf_q <= buf_d;
      out_q <= out_d;
      irq_q <= irq_d;
    end
  end

  assign cnt_o = cnt_q;
  assign out_o = out_q;
  assign irq_o = irq_q;

  // R1: a stop sampled at an edge leaves the idle state behind it
  p_stop_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (cnt_q == '1 && !out_q && !irq_q));

  // R2: the start strobe lands on zero with the output raised
  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && tick && ph_q == PH_WAIT) |=> (cnt_q == '0 && out_q));

  // R3: no strobe, no movement
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !tick) |=> ($stable(cnt_q) && $stable(out_q)));

  // R4: a match pulse comes with a cleared count
  p_irq_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> cnt_q == '0);

  // R4: a match pulse comes with a toggled output
  p_irq_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> out_q != $past(out_q));

endmodule

// File: rtl/intv_timer.sv
// Interval timer top: event synchronizer, strobe source and counter core.
module intv_timer #(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SEL_W       = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic [SEL_W-1:0] clk_sel,
  input  logic             evt_mode,
  input  logic             evt_in,
  input  logic [CNT_W-1:0] cmp_val,
  output logic             tmr_out,
  output logic             match_irq,
  output logic [CNT_W-1:0] count
);

  logic ev_edge;
  logic tick;

  intv_evsync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt_in (evt_in),
    .edge_o (ev_edge)
  );

  intv_strobe #(.SEL_W(SEL_W)) u_strobe (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_en   (run_en),
    .sel      (clk_sel),
    .ext_mode (evt_mode),
    .ext_edge (ev_edge),
    .tick_o   (tick)
  );

  intv_core #(.CNT_W(CNT_W)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_en  (run_en),
    .tick    (tick),
    .cmp_val (cmp_val),
    .cnt_o   (count),
    .out_o   (tmr_out),
    .irq_o   (match_irq)
  );

endmodule

// File: tb/intv_timer_test.sv
module intv_timer_test;

  logic        clk;
  logic        rst_n;
  logic        run_en;
  logic [2:0]  clk_sel;
  logic        evt_mode;
  logic        evt_in;
  logic [15:0] cmp_val;
  logic        tmr_out;
  logic        match_irq;
  logic [15:0] count;

  intv_timer uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_en    (run_en),
    .clk_sel   (clk_sel),
    .evt_mode  (evt_mode),
    .evt_in    (evt_in),
    .cmp_val   (cmp_val),
    .tmr_out   (tmr_out),
    .match_irq (match_irq),
    .count     (count)
  );

  typedef struct {
    int          at;
    logic [15:0] cnt;
    logic        o;
    logic        irq;
    string       tag;
  } exp_t;

  exp_t q[$];
  exp_t e;
  int   cyc = 0;
  int   n_cmp = 0;
  int   n_bad = 0;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compares every entry due in the current cycle.
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].at <= cyc) begin
      e = q.pop_front();
      n_cmp++;
      if (e.at != cyc || count !== e.cnt || tmr_out !== e.o || match_irq !== e.irq) begin
        n_bad++;
        $display("FAIL %s due %0d seen %0d: got cnt=%h out=%b irq=%b, want cnt=%h out=%b irq=%b",
                 e.tag, e.at, cyc, count, tmr_out, match_irq, e.cnt, e.o, e.irq);
      end
    end
  end

  task automatic push(input int at, input logic [15:0] c, input logic o,
                      input logic irq, input string tag);
    exp_t x;
    x.at = at; x.cnt = c; x.o = o; x.irq = irq; x.tag = tag;
    q.push_back(x);
  endtask

  task automatic go_to(input int t);
    while (cyc < t) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: got run still active, want finished");
    summary();
    $finish;
  end

  initial begin
    int c;
    rst_n = 1'b0; run_en = 1'b0; clk_sel = 3'd0; evt_mode = 1'b0;
    evt_in = 1'b0; cmp_val = 16'd0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    push(cyc, 16'hFFFF, 1'b0, 1'b0, "R1 reset");
    go_to(cyc + 2);

    // Internal tap /1, compare 3, then a rewrite to 5 mid-period.
    c = cyc; cmp_val = 16'd3; clk_sel = 3'd0; run_en = 1'b1;
    push(c+1, 16'd0, 1'b1, 1'b0, "R2 start");
    push(c+2, 16'd1, 1'b1, 1'b0, "R3 step");
    push(c+4, 16'd3, 1'b1, 1'b0, "R3 step");
    push(c+5, 16'd0, 1'b0, 1'b1, "R4 match");
    push(c+6, 16'd1, 1'b0, 1'b0, "R10 pulse end");
    push(c+9, 16'd4, 1'b0, 1'b0, "R6 old value no match");
    push(c+11, 16'd0, 1'b1, 1'b1, "R6 new value match");
    push(c+17, 16'd0, 1'b0, 1'b1, "R5 interval");
    go_to(c+3); cmp_val = 16'd5;
    go_to(c+18); run_en = 1'b0;
    push(c+19, 16'hFFFF, 1'b0, 1'b0, "R1 stop");
    push(c+21, 16'hFFFF, 1'b0, 1'b0, "R1 stopped hold");
    go_to(c+22);

    // Internal tap /4, compare 1.
    c = cyc; cmp_val = 16'd1; clk_sel = 3'd2; run_en = 1'b1;
    push(c+3, 16'hFFFF, 1'b0, 1'b0, "R7 before first strobe");
    push(c+4, 16'd0, 1'b1, 1'b0, "R7 first strobe");
    push(c+7, 16'd0, 1'b1, 1'b0, "R3 hold between strobes");
    push(c+8, 16'd1, 1'b1, 1'b0, "R7 second strobe");
    push(c+11, 16'd1, 1'b1, 1'b0, "R3 hold between strobes");
    push(c+12, 16'd0, 1'b0, 1'b1, "R5 interval /4");
    push(c+13, 16'd0, 1'b0, 1'b0, "R10 pulse end");
    go_to(c+14); run_en = 1'b0;
    go_to(c+16);

    // Internal tap /128, compare 0.
    c = cyc; cmp_val = 16'd0; clk_sel = 3'd7; run_en = 1'b1;
    push(c+127, 16'hFFFF, 1'b0, 1'b0, "R7 /128 before strobe");
    push(c+128, 16'd0, 1'b1, 1'b0, "R7 /128 first strobe");
    push(c+255, 16'd0, 1'b1, 1'b0, "R3 hold /128");
    push(c+256, 16'd0, 1'b0, 1'b1, "R4 match at zero");
    push(c+257, 16'd0, 1'b0, 1'b0, "R10 pulse end");
    go_to(c+258); run_en = 1'b0;
    go_to(c+260);

    // External events, compare 2; tap /1 selected but must be ignored.
    c = cyc; cmp_val = 16'd2; clk_sel = 3'd0; evt_mode = 1'b1; run_en = 1'b1;
    push(c+5, 16'hFFFF, 1'b0, 1'b0, "R8 no internal counting");
    go_to(c+6);
    for (int i = 0; i < 4; i++) begin
      int p;
      logic [15:0] vc;
      logic        vo;
      logic        vi;
      p = cyc;
      vc = (i == 3) ? 16'd0 : 16'(i);
      vo = (i != 3);
      vi = (i == 3);
      evt_in = 1'b1;
      push(p+2, (i == 0) ? 16'hFFFF : 16'(i-1), (i != 0), 1'b0, "R8 latency");
      push(p+3, vc, vo, vi, "R8 event strobe");
      if (i == 3) push(p+4, 16'd0, 1'b0, 1'b0, "R10 pulse end");
      push(p+6, vc, vo, 1'b0, "R8 held level");
      go_to(p+6); evt_in = 1'b0;
      go_to(p+10);
    end
    run_en = 1'b0; evt_mode = 1'b0;
    go_to(cyc + 2);

    // Restart: buffer reloads from the new compare value.
    c = cyc; cmp_val = 16'd1; clk_sel = 3'd0; run_en = 1'b1;
    push(c+1, 16'd0, 1'b1, 1'b0, "R9 restart");
    push(c+2, 16'd1, 1'b1, 1'b0, "R9 restart step");
    push(c+3, 16'd0, 1'b0, 1'b1, "R9 reload at start");
    go_to(c+4); run_en = 1'b0;
    go_to(c+8);

    if (q.size() != 0) begin
      n_cmp++;
      n_bad++;
      $display("FAIL scoreboard: got %0d pending entries, want 0", q.size());
    end
    summary();
    $finish;
  end

endmodule